// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Controller

This block produces the vertical line position for a display pipe whose frame length is not fixed. It counts lines on a one-cycle line tick from the horizontal timing logic, raises vblank from a programmed vblank-start line to the end of the frame, and pulses a frame-start strobe a programmed number of lines into each frame. In fixed mode every frame has the programmed minimum total. In variable mode the frame stretches: after the active lines and the shortest allowed vblank, the counter waits in vblank for a software push. When the push is seen, or when the last decision line is reached, it runs a vblank exit of guardband lines and starts the next frame.

Timing values are double-buffered. Software writes a shadow copy through a small register port, and the counter takes the shadow copies at one defined line per frame. That line is the vblank start in fixed mode and the vblank-exit start in variable mode. The mode switch itself takes effect at the frame boundary, and a live status output reports the mode the counter is actually running.

Top module: `vrr_timing_ctrl`

## Requirements
- R1: `line_count` advances by one on each cycle with `line_tick` high and holds otherwise. It returns to 0 after the last line of a frame. `vblank` is high while `line_count` is at or above the active vblank-start line (address 4), so an N-line frame shows N-vbs vblank lines.
- R2: With `vrr_live` low, a frame lasts (value at address 0)+1 lines. All shadow timing values (addresses 0 to 5) are copied into use on the tick that enters the vblank-start line.
- R3: With `vrr_live` high and no push, the vblank exit begins on entering line (address 1 value + 1 - guardband), so the frame lasts (address 1 value)+1 lines.
- R4: The vblank exit lasts exactly guardband lines (address 3, at least 1). A push pending when the counter enters a line at or beyond the earliest exit line, (address 2 value)+1-guardband, starts the exit on that line.
- R5: A push sent before the earliest exit line is held. The exit then starts at the earliest line, giving a frame of (address 2 value)+1 lines.
- R6: Address 6 holds bit 0 push-enable and bit 1 push-send. The send bit reads back 1 from the write until the exit that consumes it starts. A push that arrives during a vblank exit is kept for the next frame.
- R7: Writing address 6 with bit 0 clear drops any pending push and ignores bit 1.
- R8: A push written in the same cycle as the tick that consumes an earlier push survives and acts on the following frame.
- R9: In variable mode, timing values written during a frame are copied into use at that frame's exit start, so they govern the next frame.
- R10: Address 5 bit 0 (variable enable) is applied only when the counter returns to line 0. `vrr_live` (also readable at address 7 bit 0) changes only there, and the frame in progress finishes in its old mode.
- R11: `frame_start` is a one-cycle pulse in each frame, on entering line (address 5 bits 2:1)+1, a delay of 1 to 4 lines.
- R12: After reset, addresses 0 to 4 read 9, 19, 10, 2 and 6, addresses 5 and 6 read 0, and the outputs `line_count`, `vblank`, `frame_start` and `vrr_live` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_tick | input | 1 | One-cycle pulse per scan line |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | LW | Register write data |
| cfg_rdata | output | LW | Register read data for `cfg_addr` |
| line_count | output | LW | Current line within the frame |
| vblank | output | 1 | Vertical blank indicator |
| frame_start | output | 1 | One-cycle frame-start strobe |
| vrr_live | output | 1 | Variable mode running in the current frame |

## Verification
A software push and the hardware's consumption of an earlier push can land in the same cycle, and the send bit must then stay set. The bench sets a push pending early in the frame. It then issues a second push write in the very cycle that carries the line tick entering the earliest exit line. The first push must end that frame at the minimum length, and the send bit must still read 1 afterwards. The frame after that must also end at the minimum length, which shows the second push was kept for its own frame.

// File: rtl/vrr_timing_pkg.sv
package vrr_timing_pkg;

    localparam int DEF_LINE_W = 16;

    typedef enum logic [2:0] {
        A_VMIN  = 3'd0,
        A_VMAX  = 3'd1,
        A_FLIP  = 3'd2,
        A_GUARD = 3'd3,
        A_VBS   = 3'd4,
        A_CTRL  = 3'd5,
        A_PUSH  = 3'd6,
        A_STAT  = 3'd7
    } cfg_addr_e;

endpackage

// File: rtl/vrr_regs.sv
module vrr_regs
    import vrr_timing_pkg::*;
#(
    parameter int LW          = DEF_LINE_W,
    parameter int RST_VMIN_M1 = 9,
    parameter int RST_VMAX_M1 = 19,
    parameter int RST_FLIP_M1 = 10,
    parameter int RST_GUARD   = 2,
    parameter int RST_VBS     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [LW-1:0] cfg_wdata,
    output logic [LW-1:0] cfg_rdata,
    input  logic          push_consume,
    input  logic          live,
    output logic [LW-1:0] sh_vmin_m1,
    output logic [LW-1:0] sh_vmax_m1,
    output logic [LW-1:0] sh_flip_m1,
    output logic [LW-1:0] sh_guard,
    output logic [LW-1:0] sh_vbs,
    output logic [1:0]    sh_fsd,
    output logic          sh_en,
    output logic          push_pend
);

    typedef struct packed {
        logic [LW-1:0] vmin_m1;
        logic [LW-1:0] vmax_m1;
        logic [LW-1:0] flip_m1;
        logic [LW-1:0] guard;
        logic [LW-1:0] vbs;
        logic [1:0]    fsd;
        logic          en;
        logic          push_en;
        logic          push_snd;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (push_consume) r_d.push_snd = 1'b0;
        if (cfg_we) begin
            case (cfg_addr_e'(cfg_addr))
                A_VMIN:  r_d.vmin_m1 = cfg_wdata;
                A_VMAX:  r_d.vmax_m1 = cfg_wdata;
                A_FLIP:  r_d.flip_m1 = cfg_wdata;
                A_GUARD: r_d.guard   = cfg_wdata;
                A_VBS:   r_d.vbs     = cfg_wdata;
                A_CTRL: begin
                    r_d.en  = cfg_wdata[0];
                    r_d.fsd = cfg_wdata[2:1];
                end
                A_PUSH: begin
                    r_d.push_en = cfg_wdata[0];
                    if (!cfg_wdata[0])     r_d.push_snd = 1'b0;
                    else if (cfg_wdata[1]) r_d.push_snd = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{vmin_m1: LW'(RST_VMIN_M1), vmax_m1: LW'(RST_VMAX_M1),
                     flip_m1: LW'(RST_FLIP_M1), guard: LW'(RST_GUARD),
                     vbs: LW'(RST_VBS), fsd: 2'd0, en: 1'b0,
                     push_en: 1'b0, push_snd: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (cfg_addr_e'(cfg_addr))
            A_VMIN:  cfg_rdata = r_q.vmin_m1;
            A_VMAX:  cfg_rdata = r_q.vmax_m1;
            A_FLIP:  cfg_rdata = r_q.flip_m1;
            A_GUARD: cfg_rdata = r_q.guard;
            A_VBS:   cfg_rdata = r_q.vbs;
            A_CTRL:  cfg_rdata = LW'({r_q.fsd, r_q.en});
            A_PUSH:  cfg_rdata = LW'({r_q.push_snd, r_q.push_en});
            default: cfg_rdata = LW'(live);
        endcase
    end

    assign sh_vmin_m1 = r_q.vmin_m1;
    assign sh_vmax_m1 = r_q.vmax_m1;
    assign sh_flip_m1 = r_q.flip_m1;
    assign sh_guard   = r_q.guard;
    assign sh_vbs     = r_q.vbs;
    assign sh_fsd     = r_q.fsd;
    assign sh_en      = r_q.en;
    assign push_pend  = r_q.push_snd;

endmodule

// File: rtl/vrr_vcount.sv
module vrr_vcount
    import vrr_timing_pkg::*;
#(
    parameter int LW          = DEF_LINE_W,
    parameter int RST_VMIN_M1 = 9,
    parameter int RST_VMAX_M1 = 19,
    parameter int RST_FLIP_M1 = 10,
    parameter int RST_GUARD   = 2,
    parameter int RST_VBS     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_tick,
    input  logic [LW-1:0] sh_vmin_m1,
    input  logic [LW-1:0] sh_vmax_m1,
    input  logic [LW-1:0] sh_flip_m1,
    input  logic [LW-1:0] sh_guard,
    input  logic [LW-1:0] sh_vbs,
    input  logic [1:0]    sh_fsd,
    input  logic          sh_en,
    input  logic          push_pend,
    output logic          push_consume,
    output logic [LW-1:0] line_count,
    output logic          vblank,
    output logic          frame_start,
    output logic          live
);

    typedef struct packed {
        logic [LW-1:0] vmin_m1;
        logic [LW-1:0] vmax_m1;
        logic [LW-1:0] flip_m1;
        logic [LW-1:0] guard;
        logic [LW-1:0] vbs;
        logic [1:0]    fsd;
    } tset_t;

    typedef struct packed {
        tset_t         act;
        logic [LW-1:0] line;
        logic [LW-1:0] exit_end;
        logic          exiting;
        logic          live;
        logic          vblank;
        logic          fs;
    } cnt_t;

    cnt_t s_d, s_q;
    tset_t shadow;

    logic [LW-1:0] nxt, earliest, latest;
    logic          wrap;

    assign shadow = '{vmin_m1: sh_vmin_m1, vmax_m1: sh_vmax_m1,
                      flip_m1: sh_flip_m1, guard: sh_guard,
                      vbs: sh_vbs, fsd: sh_fsd};

    always_comb begin
        s_d          = s_q;
        s_d.fs       = 1'b0;
        push_consume = 1'b0;
        wrap         = 1'b0;
        nxt          = s_q.line + LW'(1);
        earliest     = s_q.act.flip_m1 + LW'(1) - s_q.act.guard;
        latest       = s_q.act.vmax_m1 + LW'(1) - s_q.act.guard;
        if (line_tick) begin
            if (s_q.live) begin
                if (s_q.exiting) begin
                    wrap = (nxt == s_q.exit_end);
                end else if (nxt >= earliest && (push_pend || nxt >= latest)) begin
                    s_d.exiting  = 1'b1;
                    s_d.exit_end = nxt + s_q.act.guard;
                    s_d.act      = shadow;
                    push_consume = push_pend;
                end
            end else begin
                if (nxt >= s_q.act.vmin_m1 + LW'(1)) begin
                    wrap = 1'b1;
                end else if (nxt == s_q.act.vbs) begin
                    s_d.act = shadow;
                end
            end
            if (wrap) begin
                s_d.line    = '0;
                s_d.exiting = 1'b0;
                s_d.live    = sh_en;
            end else begin
                s_d.line = nxt;
            end
            s_d.vblank = (s_d.line >= s_d.act.vbs);
            s_d.fs     = (s_d.line == LW'(s_d.act.fsd) + LW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{act: '{vmin_m1: LW'(RST_VMIN_M1), vmax_m1: LW'(RST_VMAX_M1),
                            flip_m1: LW'(RST_FLIP_M1), guard: LW'(RST_GUARD),
                            vbs: LW'(RST_VBS), fsd: 2'd0},
                     line: '0, exit_end: '0, exiting: 1'b0,
                     live: 1'b0, vblank: 1'b0, fs: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign line_count  = s_q.line;
    assign vblank      = s_q.vblank;
    assign frame_start = s_q.fs;
    assign live        = s_q.live;

endmodule

// File: rtl/vrr_timing_ctrl.sv
module vrr_timing_ctrl
    import vrr_timing_pkg::*;
#(
    parameter int LW          = DEF_LINE_W,
    parameter int RST_VMIN_M1 = 9,
    parameter int RST_VMAX_M1 = 19,
    parameter int RST_FLIP_M1 = 10,
    parameter int RST_GUARD   = 2,
    parameter int RST_VBS     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_tick,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [LW-1:0] cfg_wdata,
    output logic [LW-1:0] cfg_rdata,
    output logic [LW-1:0] line_count,
    output logic          vblank,
    output logic          frame_start,
    output logic          vrr_live
);

    logic [LW-1:0] sh_vmin_m1, sh_vmax_m1, sh_flip_m1, sh_guard, sh_vbs;
    logic [1:0]    sh_fsd;
    logic          sh_en, push_pend, push_consume;

    vrr_regs #(
        .LW(LW), .RST_VMIN_M1(RST_VMIN_M1), .RST_VMAX_M1(RST_VMAX_M1),
        .RST_FLIP_M1(RST_FLIP_M1), .RST_GUARD(RST_GUARD), .RST_VBS(RST_VBS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .push_consume(push_consume), .live(vrr_live),
        .sh_vmin_m1(sh_vmin_m1), .sh_vmax_m1(sh_vmax_m1), .sh_flip_m1(sh_flip_m1),
        .sh_guard(sh_guard), .sh_vbs(sh_vbs), .sh_fsd(sh_fsd), .sh_en(sh_en),
        .push_pend(push_pend)
    );

    vrr_vcount #(
        .LW(LW), .RST_VMIN_M1(RST_VMIN_M1), .RST_VMAX_M1(RST_VMAX_M1),
        .RST_FLIP_M1(RST_FLIP_M1), .RST_GUARD(RST_GUARD), .RST_VBS(RST_VBS)
    ) u_vcount (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .sh_vmin_m1(sh_vmin_m1), .sh_vmax_m1(sh_vmax_m1), .sh_flip_m1(sh_flip_m1),
        .sh_guard(sh_guard), .sh_vbs(sh_vbs), .sh_fsd(sh_fsd), .sh_en(sh_en),
        .push_pend(push_pend), .push_consume(push_consume),
        .line_count(line_count), .vblank(vblank), .frame_start(frame_start),
        .live(vrr_live)
    );

endmodule

// File: rtl/vrr_timing_chk.sv
module vrr_timing_chk
    import vrr_timing_pkg::*;
#(
    parameter int LW = DEF_LINE_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_tick,
    input logic          cfg_we,
    input logic [2:0]    cfg_addr,
    input logic [LW-1:0] line_count,
    input logic          frame_start,
    input logic          vrr_live,
    input logic          push_pend,
    input logic          push_consume
);

    a_r1_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(line_count));

    a_r1_wrap_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (line_count == '0 && $past(line_count) != '0) |-> $past(line_tick));

    a_r6_send_held: assert property (@(posedge clk) disable iff (!rst_n)
        (push_pend && !push_consume && !(cfg_we && cfg_addr == A_PUSH)) |=> push_pend);

    a_r10_live_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vrr_live) || $fell(vrr_live)) |-> line_count == '0);

    a_r11_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

endmodule

bind vrr_timing_ctrl vrr_timing_chk #(.LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .line_count(line_count), .frame_start(frame_start),
    .vrr_live(vrr_live), .push_pend(push_pend), .push_consume(push_consume)
);

// File: tb/vrr_timing_ctrl_test.sv
`timescale 1ns/1ps
module vrr_timing_ctrl_test;

    localparam logic [2:0] AD_VMIN = 3'd0, AD_GUARD = 3'd3, AD_CTRL = 3'd5,
                           AD_PUSH = 3'd6, AD_STAT = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata, line_count;
    logic        vblank, frame_start, vrr_live;

    int n_run = 0;
    int n_fail = 0;
    int len, vbl, fsc, fsl;
    logic [15:0] rv;

    always #10 clk = ~clk;

    vrr_timing_ctrl uut (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .line_count(line_count), .vblank(vblank), .frame_start(frame_start),
        .vrr_live(vrr_live)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Runs one frame from line 0 back to line 0; optionally writes a/d at line 'at'.
    task automatic run_frame(input int at, input logic [2:0] a, input logic [15:0] d,
                             input bit col, output int n, output int vb,
                             output int fc, output int fl);
        n = 0; vb = 0; fc = 0; fl = -1;
        for (int k = 0; k < 64; k++) begin
            if (int'(line_count) == at && !col) wr(a, d);
            @(negedge clk);
            line_tick = 1'b1;
            if (int'(line_count) == at && col) begin
                cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
            end
            @(negedge clk);
            line_tick = 1'b0; cfg_we = 1'b0;
            n++;
            if (frame_start) begin fc++; fl = int'(line_count); end
            if (vblank) vb++;
            if (line_count == 16'd0) break;
        end
    endtask

    task automatic t_reset;
        chk_eq("R12 line_count", int'(line_count), 0);
        chk_eq("R12 vblank", int'(vblank), 0);
        chk_eq("R12 frame_start", int'(frame_start), 0);
        chk_eq("R12 vrr_live", int'(vrr_live), 0);
        rd(3'd0, rv); chk_eq("R12 vmin reg", int'(rv), 9);
        rd(3'd1, rv); chk_eq("R12 vmax reg", int'(rv), 19);
        rd(3'd2, rv); chk_eq("R12 flip reg", int'(rv), 10);
        rd(3'd3, rv); chk_eq("R12 guard reg", int'(rv), 2);
        rd(3'd4, rv); chk_eq("R12 vbs reg", int'(rv), 6);
        rd(AD_PUSH, rv); chk_eq("R12 push reg", int'(rv), 0);
    endtask

    task automatic t_fixed;
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R2 fixed length", len, 10);
        chk_eq("R1 vblank lines", vbl, 4);
        chk_eq("R11 fs count", fsc, 1);
        chk_eq("R11 fs line", fsl, 1);
        wr(AD_VMIN, 16'd11);
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R2 latched at vbs length", len, 12);
        run_frame(7, AD_VMIN, 16'd9, 0, len, vbl, fsc, fsl);
        chk_eq("R2 late write not this frame", len, 12);
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R2 late write next frame", len, 10);
    endtask

    task automatic t_enable;
        wr(AD_CTRL, 16'd1);
        chk_eq("R10 live held before wrap", int'(vrr_live), 0);
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R10 enabling frame fixed", len, 10);
        chk_eq("R10 live after wrap", int'(vrr_live), 1);
        rd(AD_STAT, rv); chk_eq("R10 status reg", int'(rv), 1);
        wr(AD_PUSH, 16'd1);
    endtask

    task automatic t_no_push;
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R3 stretch to vmax", len, 20);
        chk_eq("R1 vrr vblank lines", vbl, 14);
    endtask

    task automatic t_early_push;
        wr(AD_PUSH, 16'd3);
        rd(AD_PUSH, rv); chk_eq("R6 send reads set", int'(rv), 3);
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R5 early push gives flipline", len, 11);
        rd(AD_PUSH, rv); chk_eq("R6 send cleared", int'(rv), 1);
    endtask

    task automatic t_mid_push;
        run_frame(13, AD_PUSH, 16'd3, 0, len, vbl, fsc, fsl);
        chk_eq("R4 mid push exit length", len, 16);
    endtask

    task automatic t_late_push;
        run_frame(19, AD_PUSH, 16'd3, 0, len, vbl, fsc, fsl);
        chk_eq("R6 late push frame", len, 20);
        rd(AD_PUSH, rv); chk_eq("R6 late push pending", int'(rv), 3);
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R6 late push next frame", len, 11);
    endtask

    task automatic t_ignored;
        run_frame(2, AD_PUSH, 16'd2, 0, len, vbl, fsc, fsl);
        chk_eq("R7 disabled send ignored", len, 20);
        rd(AD_PUSH, rv); chk_eq("R7 nothing pending", int'(rv), 0);
        wr(AD_PUSH, 16'd3);
        wr(AD_PUSH, 16'd0);
        rd(AD_PUSH, rv); chk_eq("R7 clear drops push", int'(rv), 0);
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R7 dropped push no effect", len, 20);
        wr(AD_PUSH, 16'd1);
    endtask

    task automatic t_collide;
        wr(AD_PUSH, 16'd3);
        run_frame(8, AD_PUSH, 16'd3, 1, len, vbl, fsc, fsl);
        chk_eq("R8 first push frame", len, 11);
        rd(AD_PUSH, rv); chk_eq("R8 second push kept", int'(rv), 3);
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R8 second push frame", len, 11);
    endtask

    task automatic t_guard;
        run_frame(2, AD_GUARD, 16'd4, 0, len, vbl, fsc, fsl);
        chk_eq("R9 guard write frame", len, 20);
        run_frame(8, AD_PUSH, 16'd3, 0, len, vbl, fsc, fsl);
        chk_eq("R9 R4 guard 4 exit", len, 13);
        run_frame(2, AD_GUARD, 16'd2, 0, len, vbl, fsc, fsl);
        chk_eq("R3 vmax with guard 4", len, 20);
        run_frame(8, AD_PUSH, 16'd3, 0, len, vbl, fsc, fsl);
        chk_eq("R9 guard back to 2", len, 11);
    endtask

    task automatic t_fs_delay;
        run_frame(2, AD_CTRL, 16'd7, 0, len, vbl, fsc, fsl);
        chk_eq("R11 old delay this frame", fsl, 1);
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R11 fs count delay 4", fsc, 1);
        chk_eq("R11 fs line delay 4", fsl, 4);
    endtask

    task automatic t_disable;
        wr(AD_CTRL, 16'd6);
        chk_eq("R10 live stays after clear", int'(vrr_live), 1);
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R10 frame completes in vrr", len, 20);
        chk_eq("R10 live dropped at wrap", int'(vrr_live), 0);
        run_frame(-1, 3'd0, 16'd0, 0, len, vbl, fsc, fsl);
        chk_eq("R2 back to fixed", len, 10);
        chk_eq("R1 fixed vblank again", vbl, 4);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fixed;
        t_enable;
        t_no_push;
        t_early_push;
        t_mid_push;
        t_late_push;
        t_ignored;
        t_collide;
        t_guard;
        t_fs_delay;
        t_disable;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule